// File: doc/BRIEF.md
# Byte Shuffle and Sign-Extend Unit

This unit computes the result of the register byte-shuffle instruction group. The instruction word arrives with the `rt` source operand. The group sits under major opcode 0x1F and has two function codes. Function 0x20 holds the word-sized operations. Function 0x24 holds the doubleword operations, which exist only in 64-bit mode. A 5-bit selector in instruction bits [10:6] picks the sub-operation within a function code. The operations are:

- sign-extend the low byte;
- sign-extend the low halfword;
- swap the two bytes of every halfword, either in the low word (then sign-extended) or across the whole doubleword;
- reverse the order of the four halfwords of the doubleword.

The datapath is combinational. One register stage follows it, and it carries a valid flag, so a result leaves the unit one cycle after its operands are presented. An instruction this unit cannot execute raises an illegal flag and gives a zero result. This covers three cases: a selector the group does not define, a doubleword operation outside 64-bit mode, and an opcode or function code outside the group. The destination register index (`rd`, bits [15:11]) travels alongside the result.

Top module: `bsx_unit`

## Requirements
- R1: While reset is high, and on the first cycle after it, `out_valid`, `out_illegal`, `out_rd` and `out_result` are all zero.
- R2: `out_valid` equals `in_valid` from one cycle earlier. A cycle with `in_valid` low gives zero on `out_result` and `out_illegal` in the following cycle.
- R3: With opcode bits [31:26]=0x1F, function bits [5:0]=0x20 and selector bits [10:6]=0x10, the result is `rt[7:0]` sign-extended to 64 bits.
- R4: With function 0x20 and selector 0x18, the result is `rt[15:0]` sign-extended to 64 bits.
- R5: With function 0x20 and selector 0x02, the bytes of each halfword of `rt[31:0]` are exchanged, giving `{rt[23:16],rt[31:24],rt[7:0],rt[15:8]}`. Bit 31 of that word is copied into bits [63:32].
- R6: With function 0x24, selector 0x02 and `wide_mode` high, every one of the four halfwords of `rt` has its two bytes exchanged.
- R7: With function 0x24, selector 0x05 and `wide_mode` high, the result is `{rt[15:0],rt[31:16],rt[47:32],rt[63:48]}`.
- R8: Function 0x24 with `wide_mode` low sets `out_illegal` and gives a zero result, whatever the selector.
- R9: Any other selector under either function, or an opcode or function code outside the group, sets `out_illegal` and gives a zero result. Whenever `out_illegal` is high, `out_result` is zero.
- R10: For every accepted instruction, legal or not, `out_rd` equals instruction bits [15:11] in the cycle after `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and instruction present this cycle |
| in_insn | input | 32 | Instruction word |
| in_rt | input | DATA_W | Source operand `rt` |
| wide_mode | input | 1 | 64-bit mode; enables the doubleword operations |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_result | output | DATA_W | Computed value for the destination register |
| out_rd | output | 5 | Destination register index |
| out_illegal | output | 1 | Instruction not executable by this unit |

## Verification
The bench steps through all 32 selector values under both function codes, with `wide_mode` both low and high. Each combination is tried against eight `rt` patterns.

- Ascending and descending byte sequences show whether bytes or halfwords end up in the wrong lane.
- Patterns that differ only in bit 7, bit 15 or bit 23 show whether each sign extension takes the right source bit.
- All-zero and all-one words expose constant stuck bits.

Instructions from outside the group, and idle cycles between vectors, confirm that the illegal path and the idle path both clear the result.

// File: rtl/bsx_pkg.sv
package bsx_pkg;

    localparam logic [5:0] MAJOR_SPECIAL3 = 6'h1F;
    localparam logic [5:0] FN_WORD_GROUP  = 6'h20;
    localparam logic [5:0] FN_DWORD_GROUP = 6'h24;

    localparam logic [4:0] SEL_SEXT_BYTE  = 5'h10;
    localparam logic [4:0] SEL_SEXT_HALF  = 5'h18;
    localparam logic [4:0] SEL_BYTE_SWAP  = 5'h02;
    localparam logic [4:0] SEL_HALF_REV   = 5'h05;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_SEXT_B,
        OP_SEXT_H,
        OP_WORD_BSWAP,
        OP_DWORD_BSWAP,
        OP_HALF_REV
    } shuf_op_e;

    typedef struct packed {
        shuf_op_e   op;
        logic       illegal;
        logic [4:0] rd;
    } shuf_ctl_t;

    function automatic logic [5:0] major_of(input logic [31:0] insn);
        return insn[31:26];
    endfunction

    function automatic logic [5:0] funct_of(input logic [31:0] insn);
        return insn[5:0];
    endfunction

    function automatic logic [4:0] sel_of(input logic [31:0] insn);
        return insn[10:6];
    endfunction

    function automatic logic [4:0] rd_of(input logic [31:0] insn);
        return insn[15:11];
    endfunction

endpackage

// File: rtl/bsx_decode.sv
module bsx_decode
    import bsx_pkg::*;
(
    input  logic [5:0] major,
    input  logic [5:0] funct,
    input  logic [4:0] sel,
    input  logic [4:0] rd,
    input  logic       wide_mode,
    output shuf_ctl_t  ctl
);

    shuf_op_e op;

    always_comb begin
        op = OP_NONE;
        if (major == MAJOR_SPECIAL3) begin
            if (funct == FN_WORD_GROUP) begin
                case (sel)
                    SEL_SEXT_BYTE: op = OP_SEXT_B;
                    SEL_SEXT_HALF: op = OP_SEXT_H;
                    SEL_BYTE_SWAP: op = OP_WORD_BSWAP;
                    default:       op = OP_NONE;
                endcase
            end else if (funct == FN_DWORD_GROUP && wide_mode) begin
                case (sel)
                    SEL_BYTE_SWAP: op = OP_DWORD_BSWAP;
                    SEL_HALF_REV:  op = OP_HALF_REV;
                    default:       op = OP_NONE;
                endcase
            end
        end
    end

    always_comb begin
        ctl.op      = op;
        ctl.illegal = (op == OP_NONE);
        ctl.rd      = rd;
    end

endmodule

// File: rtl/bsx_datapath.sv
module bsx_datapath
    import bsx_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  shuf_op_e          op,
    input  logic [DATA_W-1:0] rt,
    output logic [DATA_W-1:0] result
);

    localparam int HALF_W = 16;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 32;
    localparam int NUM_HW = DATA_W / HALF_W;

    logic [DATA_W-1:0] swapped;
    logic [DATA_W-1:0] reversed;

    for (genvar g = 0; g < NUM_HW; g++) begin : g_lane
        assign swapped[g*HALF_W +: HALF_W] =
            {rt[g*HALF_W +: BYTE_W], rt[g*HALF_W + BYTE_W +: BYTE_W]};
        assign reversed[g*HALF_W +: HALF_W] =
            rt[(NUM_HW-1-g)*HALF_W +: HALF_W];
    end

    always_comb begin
        case (op)
            OP_SEXT_B:      result = {{(DATA_W-BYTE_W){rt[BYTE_W-1]}}, rt[BYTE_W-1:0]};
            OP_SEXT_H:      result = {{(DATA_W-HALF_W){rt[HALF_W-1]}}, rt[HALF_W-1:0]};
            OP_WORD_BSWAP:  result = {{(DATA_W-WORD_W){swapped[WORD_W-1]}}, swapped[WORD_W-1:0]};
            OP_DWORD_BSWAP: result = swapped;
            OP_HALF_REV:    result = reversed;
            default:        result = '0;
        endcase
    end

endmodule

// File: rtl/bsx_unit.sv
module bsx_unit
    import bsx_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [31:0]       in_insn,
    input  logic [DATA_W-1:0] in_rt,
    input  logic              wide_mode,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic [4:0]        out_rd,
    output logic              out_illegal
);

    localparam int BYTE_W = 8;
    localparam int WORD_W = 32;

    shuf_ctl_t         ctl;
    logic [DATA_W-1:0] comb_result;
    logic              unused_fields;

    assign unused_fields = ^in_insn[25:16];

    bsx_decode u_decode (
        .major     (major_of(in_insn)),
        .funct     (funct_of(in_insn)),
        .sel       (sel_of(in_insn)),
        .rd        (rd_of(in_insn)),
        .wide_mode (wide_mode),
        .ctl       (ctl)
    );

    bsx_datapath #(.DATA_W(DATA_W)) u_datapath (
        .op     (ctl.op),
        .rt     (in_rt),
        .result (comb_result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_result  <= '0;
            out_rd      <= '0;
            out_illegal <= 1'b0;
        end else begin
            out_valid   <= in_valid;
            out_rd      <= in_valid ? ctl.rd : 5'd0;
            out_illegal <= in_valid & ctl.illegal;
            out_result  <= in_valid ? comb_result : '0;
        end
    end

    // R2
    valid_pipe_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (out_valid == $past(in_valid)));

    // R2
    idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (out_result == '0 && !out_illegal));

    // R9
    illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> (out_result == '0));

    // R3
    byte_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctl.op == OP_SEXT_B) |=>
        (out_result[DATA_W-1:BYTE_W] == {(DATA_W-BYTE_W){out_result[BYTE_W-1]}}));

    // R5
    word_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctl.op == OP_WORD_BSWAP) |=>
        (out_result[DATA_W-1:WORD_W] == {(DATA_W-WORD_W){out_result[WORD_W-1]}}));

    // R8
    mode_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !wide_mode && in_insn[31:26] == 6'h1F && in_insn[5:0] == 6'h24)
        |=> out_illegal);

    // R10
    rd_track_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_rd == $past(in_insn[15:11])));

endmodule

// File: tb/sim_bsx_unit.sv
module sim_bsx_unit;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 64;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [31:0]       in_insn = '0;
    logic [DATA_W-1:0] in_rt = '0;
    logic              wide_mode = 1'b0;
    logic              out_valid;
    logic [DATA_W-1:0] out_result;
    logic [4:0]        out_rd;
    logic              out_illegal;

    int  n_vec  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bsx_unit #(.DATA_W(DATA_W)) u0 (
        .clk, .rst, .in_valid, .in_insn, .in_rt, .wide_mode,
        .out_valid, .out_result, .out_rd, .out_illegal
    );

    function automatic void model(input logic [31:0] insn, input logic [63:0] rt,
                                  input bit wide, output logic [63:0] r,
                                  output bit ill, output string tag);
        logic [31:0] w;
        r = '0; ill = 1'b1; tag = "R9";
        if (insn[31:26] == 6'h1F && insn[5:0] == 6'h20) begin
            case (insn[10:6])
                5'h10: begin r = 64'($signed(rt[7:0]));  ill = 0; tag = "R3"; end
                5'h18: begin r = 64'($signed(rt[15:0])); ill = 0; tag = "R4"; end
                5'h02: begin
                    w = ((rt[31:0] & 32'hFF00FF00) >> 8) | ((rt[31:0] & 32'h00FF00FF) << 8);
                    r = 64'($signed(w)); ill = 0; tag = "R5";
                end
                default: tag = "R9";
            endcase
        end else if (insn[31:26] == 6'h1F && insn[5:0] == 6'h24) begin
            if (!wide) tag = "R8";
            else case (insn[10:6])
                5'h02: begin
                    r = ((rt & 64'hFF00FF00FF00FF00) >> 8) | ((rt & 64'h00FF00FF00FF00FF) << 8);
                    ill = 0; tag = "R6";
                end
                5'h05: begin r = {rt[15:0], rt[31:16], rt[47:32], rt[63:48]}; ill = 0; tag = "R7"; end
                default: tag = "R9";
            endcase
        end
    endfunction

    task automatic apply(input logic [31:0] insn, input logic [63:0] rt, input bit wide);
        logic [63:0] er; bit ei; string tag;
        model(insn, rt, wide, er, ei, tag);
        @(negedge clk);
        in_valid = 1'b1; in_insn = insn; in_rt = rt; wide_mode = wide;
        @(negedge clk);
        in_valid = 1'b0;
        n_vec++;
        if (out_result !== er || out_illegal !== ei || out_rd !== insn[15:11] || out_valid !== 1'b1) begin
            n_fail++;
            $display("FAIL %s/R2/R10 insn=%h rt=%h: result=%h ill=%0b rd=%0d v=%0b expected result=%h ill=%0b rd=%0d v=1",
                     tag, insn, rt, out_result, out_illegal, out_rd, out_valid, er, ei, insn[15:11]);
        end
        @(negedge clk);
        n_vec++;
        // R2: idle cycle clears the result
        if (out_valid !== 1'b0 || out_result !== '0 || out_illegal !== 1'b0) begin
            n_fail++;
            $display("FAIL R2 idle: v=%0b result=%h ill=%0b expected v=0 result=0 ill=0",
                     out_valid, out_result, out_illegal);
        end
    endtask

    initial begin
        logic [63:0] pats [8];
        pats[0] = 64'h0123456789ABCDEF;
        pats[1] = 64'hFEDCBA9876543210;
        pats[2] = 64'h000000000000807F;
        pats[3] = 64'h800000007FFF0080;
        pats[4] = 64'h0000000000800000;
        pats[5] = 64'hFFFFFFFFFF7FFFFF;
        pats[6] = 64'h0;
        pats[7] = 64'hFFFFFFFFFFFFFFFF;
        repeat (3) @(negedge clk);
        n_vec++;
        // R1: reset state
        if (out_valid !== 0 || out_result !== '0 || out_rd !== 0 || out_illegal !== 0) begin
            n_fail++;
            $display("FAIL R1 reset: v=%0b result=%h rd=%0d ill=%0b expected all zero",
                     out_valid, out_result, out_rd, out_illegal);
        end
        rst = 1'b0;
        @(negedge clk);
        n_vec++;
        if (out_valid !== 0 || out_result !== '0) begin
            n_fail++;
            $display("FAIL R1 post-reset: v=%0b result=%h expected 0/0", out_valid, out_result);
        end
        for (int fsel = 0; fsel < 2; fsel++)
            for (int wd = 0; wd < 2; wd++)
                for (int s = 0; s < 32; s++)
                    for (int p = 0; p < 8; p++) begin
                        logic [5:0] fn;
                        logic [4:0] rd;
                        fn = (fsel == 0) ? 6'h20 : 6'h24;
                        rd = 5'(s ^ (p * 5) ^ wd);
                        apply({6'h1F, 5'(p), 5'(s), rd, 5'(s), fn}, pats[p], wd[0]);
                    end
        // R9: outside the group
        for (int p = 0; p < 8; p++) begin
            apply({6'h00, 10'h155, 5'd7, 5'h10, 6'h20}, pats[p], 1'b1);
            apply({6'h1F, 10'h0AA, 5'd9, 5'h02, 6'h25}, pats[p], 1'b1);
            apply({6'h1E, 10'h0F0, 5'd31, 5'h05, 6'h24}, pats[p], 1'b1);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule